// File: doc/BRIEF.md
# Threshold Interrupt Flag Controller

This block watches the stream of conversion results from a light or similar sensor and decides when to raise a threshold interrupt. Each time a new result arrives, it is compared against a programmable upper and lower limit. A result only counts as a limit event after it has stayed outside the same limit for a configurable number of consecutive conversions. This filter stops a single noisy sample from raising an alarm.

The block keeps an above-limit flag, a below-limit flag, a conversion-ready bit and an internal interrupt state. The interrupt state drives a pin whose polarity is selectable. A latch bit chooses between two modes:

- **Latched window mode:** events are held until software reads the configuration register. An alert-response cycle withdraws only the pin.
- **Transparent hysteresis mode:** the flags and the pin simply follow the most recent qualified event.

The surrounding register file supplies the limits and settings. It also pulses the configuration read, configuration write and alert-response strobes. The conversion engine pulses the result-valid strobe.

Top module: `thresh_irq_flags`

## Requirements
- R1: The fault-count field `fault_sel` encodes the required number of consecutive conversions: 0 = 1, 1 = 2, 2 = 4, 3 = 8. A high event needs that many consecutive results strictly greater (unsigned) than `lim_high`. A low event needs that many consecutive results strictly less (unsigned) than `lim_low`. Any conversion that fails a condition restarts that condition's count.
- R2: With `latch_mode`=1, a high event sets `flag_hi` and makes the interrupt active, leaving `flag_lo` unchanged. A low event sets `flag_lo` and makes the interrupt active, leaving `flag_hi` unchanged.
- R3: With `latch_mode`=1, `cfg_rd` clears both flags and makes the interrupt inactive. `alert_ack` makes the interrupt inactive and leaves both flags as they were.
- R4: With `latch_mode`=0, a high event gives `flag_hi`=1, `flag_lo`=0 and an active interrupt. A low event gives `flag_lo`=1, `flag_hi`=0 and an inactive interrupt.
- R5: With `latch_mode`=0, `cfg_rd`, `cfg_wr` and `alert_ack` leave both flags and the interrupt unchanged.
- R6: Every `res_valid` pulse sets `conv_rdy` to 1 on the next cycle, whether or not an event occurred.
- R7: `cfg_rd` leaves `conv_rdy` unchanged during the read cycle and clears it from the next cycle. Two back-to-back reads after a conversion therefore see 1 and then 0.
- R8: `cfg_wr` with `cfg_mode` not equal to 2'b00 clears `conv_rdy`. `cfg_wr` with `cfg_mode`=2'b00 (shutdown) changes nothing in this block.
- R9: `int_pin` is 0 when the interrupt is active with `pol`=0, or when it is inactive with `pol`=1. Otherwise it is 1.
- R10: After reset, `flag_hi`, `flag_lo` and `conv_rdy` are 0 and the interrupt is inactive.
- R11: When `res_valid` arrives in the same cycle as a clearing strobe, the conversion's effects win. `conv_rdy` becomes 1, and any event it qualifies sets its flag and interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle pulse: a new result is present |
| res_value | input | DW | Conversion result |
| lim_high | input | DW | Upper limit |
| lim_low | input | DW | Lower limit |
| fault_sel | input | 2 | Consecutive-count select |
| pol | input | 1 | Interrupt pin polarity (1 = active high) |
| latch_mode | input | 1 | 1 = latched window, 0 = transparent hysteresis |
| cfg_rd | input | 1 | Configuration register read pulse |
| cfg_wr | input | 1 | Configuration register write pulse |
| cfg_mode | input | 2 | Mode field written with `cfg_wr` |
| alert_ack | input | 1 | Alert-response pulse |
| flag_hi | output | 1 | Above-limit flag |
| flag_lo | output | 1 | Below-limit flag |
| conv_rdy | output | 1 | Conversion-ready bit |
| int_pin | output | 1 | Interrupt pin level |

## Verification
Faults in this block surface at the ports in different ways:

- **Fault counter:** an off-by-one count moves the flag edge one conversion earlier or later. A counter that fails to restart lets a broken run of out-of-limit results raise an event it should not.
- **Interrupt state:** a corrupted state shows on `int_pin` in the cycle after the offending strobe, inverted according to `pol`.
- **Mode confusion:** a mix-up between the two modes appears as flags that survive a read, or that clear when they should not.
- **Ready bit:** a ready bit cleared too early is caught by the back-to-back read pattern.

All of these are visible one clock after the stimulus, so the bench samples every output one cycle after each strobe.

// File: rtl/thresh_irq_flags.sv
module thresh_irq_flags #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [DW-1:0] res_value,
  input  logic [DW-1:0] lim_high,
  input  logic [DW-1:0] lim_low,
  input  logic [1:0]    fault_sel,
  input  logic          pol,
  input  logic          latch_mode,
  input  logic          cfg_rd,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_mode,
  input  logic          alert_ack,
  output logic          flag_hi,
  output logic          flag_lo,
  output logic          conv_rdy,
  output logic          int_pin
);

  localparam logic [CW-1:0] CNT_MAX = CW'(8);

  logic [CW-1:0] hi_cnt, lo_cnt;
  logic [CW:0]   hi_inc, lo_inc, need;
  logic          above, below, hi_evt, lo_evt, act;

  assign need   = (CW+1)'(1) << fault_sel;
  assign above  = res_value > lim_high;
  assign below  = res_value < lim_low;
  assign hi_inc = {1'b0, hi_cnt} + (CW+1)'(1);
  assign lo_inc = {1'b0, lo_cnt} + (CW+1)'(1);
  assign hi_evt = res_valid && above && (hi_inc >= need);
  assign lo_evt = res_valid && below && (lo_inc >= need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (res_valid) begin
      hi_cnt <= !above ? '0 : (hi_cnt >= CNT_MAX) ? CNT_MAX : hi_inc[CW-1:0];
      lo_cnt <= !below ? '0 : (lo_cnt >= CNT_MAX) ? CNT_MAX : lo_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
      act     <= 1'b0;
    end else if (latch_mode) begin
      if (hi_evt || lo_evt) begin
        if (hi_evt) flag_hi <= 1'b1;
        if (lo_evt) flag_lo <= 1'b1;
        act <= 1'b1;
      end else if (cfg_rd) begin
        flag_hi <= 1'b0;
        flag_lo <= 1'b0;
        act     <= 1'b0;
      end else if (alert_ack) begin
        act <= 1'b0;
      end
    end else begin
      if (hi_evt) begin
        flag_hi <= 1'b1;
        flag_lo <= 1'b0;
        act     <= 1'b1;
      end else if (lo_evt) begin
        flag_hi <= 1'b0;
        flag_lo <= 1'b1;
        act     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            conv_rdy <= 1'b0;
    else if (res_valid)                    conv_rdy <= 1'b1;
    else if (cfg_rd)                       conv_rdy <= 1'b0;
    else if (cfg_wr && cfg_mode != 2'b00)  conv_rdy <= 1'b0;
  end

  assign int_pin = ~(act ^ pol);

  assert_conv_sets_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> conv_rdy);

  assert_read_clears_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !res_valid) |=> !conv_rdy);

  assert_shutdown_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == 2'b00 && !cfg_rd && !res_valid) |=> $stable(conv_rdy));

  assert_latched_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && cfg_rd && !res_valid) |=> (!flag_hi && !flag_lo && !act));

  assert_transparent_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !res_valid) |=> ($stable(flag_hi) && $stable(flag_lo) && $stable(act)));

  assert_flags_rise_on_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (!$rose(flag_hi) && !$rose(flag_lo)));

  assert_conv_wins_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cfg_rd) |=> conv_rdy);

endmodule

// File: tb/thresh_irq_flags_tb.sv
module thresh_irq_flags_tb;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [DW-1:0] res_value = '0;
  logic [DW-1:0] lim_high = 16'd1000;
  logic [DW-1:0] lim_low = 16'd100;
  logic [1:0] fault_sel = 2'd1;
  logic pol = 1'b0;
  logic latch_mode = 1'b1;
  logic cfg_rd = 1'b0, cfg_wr = 1'b0, alert_ack = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic flag_hi, flag_lo, conv_rdy, int_pin;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  thresh_irq_flags #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .lim_high(lim_high), .lim_low(lim_low), .fault_sel(fault_sel), .pol(pol),
    .latch_mode(latch_mode), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .alert_ack(alert_ack), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .conv_rdy(conv_rdy), .int_pin(int_pin)
  );

  // op: 0 conversion, 1 config read, 2 alert response, 3 write mode 01, 4 write mode 00
  // entry = {op[2:0], value[15:0], flag_hi, flag_lo, conv_rdy, int_pin}
  localparam int NV = 15;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 16'd2000, 4'b0011},  // R1 first high, count 1 of 2
    {3'd1, 16'd0,    4'b0001},  // R7
    {3'd0, 16'd2000, 4'b1010},  // R2 high event
    {3'd3, 16'd0,    4'b1000},  // R8 write non-shutdown
    {3'd2, 16'd0,    4'b1001},  // R3 alert drops pin only
    {3'd0, 16'd500,  4'b1011},  // R6
    {3'd1, 16'd0,    4'b0001},  // R3 read clears
    {3'd0, 16'd50,   4'b0011},  // R1 low count 1
    {3'd0, 16'd100,  4'b0011},  // R1 equal is not below, restart
    {3'd0, 16'd50,   4'b0011},  // R1 low count 1
    {3'd0, 16'd50,   4'b0110},  // R2 low event
    {3'd4, 16'd0,    4'b0110},  // R8 shutdown write inert
    {3'd3, 16'd0,    4'b0100},  // R8
    {3'd0, 16'd1000, 4'b0110},  // R1 equal is not above
    {3'd1, 16'd0,    4'b0001}   // R3
  };

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if ({flag_hi, flag_lo, conv_rdy, int_pin} !== exp) begin
      fails++;
      $display("FAIL %s: {hi,lo,rdy,int} actual=%b expected=%b", req,
               {flag_hi, flag_lo, conv_rdy, int_pin}, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [DW-1:0] v);
    @(negedge clk);
    res_valid = (op == 3'd0);
    res_value = v;
    cfg_rd    = (op == 3'd1);
    alert_ack = (op == 3'd2);
    cfg_wr    = (op == 3'd3) || (op == 3'd4);
    cfg_mode  = (op == 3'd3) ? 2'b01 : 2'b00;
    @(negedge clk);
    res_valid = 1'b0; cfg_rd = 1'b0; alert_ack = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic conv(input logic [DW-1:0] v);
    step(3'd0, v);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", 4'b0001);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22:20], VEC[i][19:4]);
      check($sformatf("vector %0d", i), VEC[i][3:0]);
    end

    // Transparent mode, active-high pin, single-count filter
    latch_mode = 1'b0; pol = 1'b1; fault_sel = 2'd0;
    @(negedge clk);
    check("R9 inactive with pol=1 drives low", 4'b0000);
    conv(16'd2000);
    check("R4 high event", 4'b1011);
    step(3'd1, 0);
    check("R5 read leaves flags and pin", 4'b1001);
    step(3'd2, 0);
    check("R5 alert ignored", 4'b1001);
    step(3'd3, 0);
    check("R5 write leaves flags", 4'b1001);
    conv(16'd10);
    check("R4 low event", 4'b0110);

    // Eight-count filter with an interrupted run
    fault_sel = 2'd3;
    for (int i = 0; i < 7; i++) conv(16'd2000);
    check("R1 seven of eight", 4'b0110);
    conv(16'd500);
    for (int i = 0; i < 7; i++) conv(16'd2000);
    check("R1 restart after break", 4'b0110);
    conv(16'd2000);
    check("R1 eighth consecutive", 4'b1011);

    // Four-count filter on the low side
    fault_sel = 2'd2;
    for (int i = 0; i < 3; i++) conv(16'd5);
    check("R1 three of four", 4'b1011);
    conv(16'd5);
    check("R1 fourth consecutive low", 4'b0110);

    // Back-to-back reads
    conv(16'd500);
    step(3'd1, 0);
    check("R7 first read sees ready", 4'b0100);

    // Latched mode, same-cycle priority
    latch_mode = 1'b1; pol = 1'b0; fault_sel = 2'd0;
    step(3'd1, 0);
    check("R3 read clears latched", 4'b0001);
    @(negedge clk);
    res_valid = 1'b1; res_value = 16'd3000; cfg_rd = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; cfg_rd = 1'b0;
    check("R11 conversion beats read", 4'b1010);
    @(negedge clk);
    res_valid = 1'b1; res_value = 16'd1; alert_ack = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; alert_ack = 1'b0;
    check("R11 conversion beats alert", 4'b1110);

    // Reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 mid-run reset", 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule